// File: doc/BRIEF.md
# Embedded CPU debug halt controller

This block holds the mode and state control words of a small embedded processor core and turns debug events from that core into a halt signal. Software reaches both words over a plain register bus: address, write data, write strobe, read strobe and read data. The mode word sets the core-local reset, single-step, two address-window trap enables, and the enables for watchdog, data cache and write posting. The state word keeps sticky cause bits, which a write of 1 clears.

The core reports instruction fetch and data access addresses with valid flags. It also pulses on an overflow of its request FIFO or of its data/bytemask FIFO, on a blocking cache miss and on a watchdog interrupt. A trap fires when an enabled access falls in the lowest 256 bytes. A trap cause or either overflow cause halts the core. A blocking miss is only recorded.

Single-step lets a halted core run for one clock. The core halts again if a cause is still set. A watchdog interrupt drops the trap enables and the watchdog enable, which releases a core held only by trap causes.

Top module: `core_dbg_ctl`

## Requirements
- R1: After reset, the mode word reads 0x40 (boot-fail flag, bit 6, set) and the state word reads 0. core_halt, core_step, core_rst, wdog_en, dcache_en and wpost_en are all 0.
- R2: Writing 1 to mode bit 0 drives core_rst high for exactly the one cycle after the write. Mode bit 0 always reads 0.
- R3: Mode bits 4 (wpost_en), 5 (dcache_en), 6 (boot-fail flag) and 7 (wdog_en) are ordinary read/write bits. Bits 4, 5 and 7 drive the outputs of the same name.
- R4: While mode bit 3 is set, a valid instruction fetch to a byte address below 256 sets state bit 4 at the next clock, and core_halt is then high. Addresses of 256 and above have no effect. With mode bit 3 clear, no fetch has an effect.
- R5: While mode bit 2 is set, a valid data access to a byte address below 256 sets state bit 3 at the next clock, and core_halt is then high. Addresses of 256 and above have no effect. With mode bit 2 clear, no access has an effect.
- R6: A request-FIFO overflow pulse sets state bit 30. A data/bytemask-FIFO overflow pulse sets state bit 29. Either bit holds core_halt high.
- R7: A blocking cache miss pulse sets state bit 31 and does not raise core_halt.
- R8: State cause bits clear only when 1 is written to them. Writing 0 leaves them unchanged. A cause that fires in the same cycle as its clear leaves the bit set.
- R9: A watchdog interrupt clears mode bits 2, 3 and 7 and wins over a mode write in the same cycle. The other mode bits are unchanged. Latched trap cause bits stay set but no longer hold core_halt.
- R10: Writing 1 to mode bit 1 while core_halt is high drives core_step high for exactly the next cycle, with core_halt low in that cycle. core_halt returns afterwards if a cause is still set. The write is ignored while not halted, and mode bit 1 always reads 0.
- R11: Mode decodes at offset 0x0 and state at offset 0x4. Every other offset and every unimplemented bit reads 0. Writes to other offsets have no effect. reg_rdata is 0 while reg_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational |
| ifetch_addr | input | AW | Instruction fetch byte address |
| ifetch_valid | input | 1 | Fetch address valid |
| daccess_addr | input | AW | Data access byte address |
| daccess_valid | input | 1 | Data address valid |
| req_fifo_ovf | input | 1 | Request FIFO overflow pulse |
| mask_fifo_ovf | input | 1 | Data/bytemask FIFO overflow pulse |
| cache_block_miss | input | 1 | Blocking cache miss pulse |
| wdog_irq | input | 1 | Watchdog interrupt pulse |
| core_halt | output | 1 | Halt request to the core |
| core_step | output | 1 | One-cycle step enable |
| core_rst | output | 1 | Core-local reset pulse |
| wdog_en | output | 1 | Watchdog enable |
| dcache_en | output | 1 | Data cache enable |
| wpost_en | output | 1 | Multiple write posting enable |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled on the rising edge. They also assume that the register bus presents at most one write per cycle, with address and data stable while the strobe is high. The bench drives every input on the falling edge and holds each event for exactly one cycle. It sweeps fetch and data addresses across the trap boundary, so every trap check sees clean one-cycle events. Register writes, single-step requests and watchdog interrupts are each issued in their own cycle. The exception is the cases that deliberately make a clear coincide with a cause, or a mode write coincide with a watchdog interrupt.

// File: rtl/core_dbg_ctl.sv
module core_dbg_ctl #(
  parameter int ADDR_W     = 8,
  parameter int AW         = 12,
  parameter int TRAP_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [31:0]       reg_rdata,
  input  logic [AW-1:0]     ifetch_addr,
  input  logic              ifetch_valid,
  input  logic [AW-1:0]     daccess_addr,
  input  logic              daccess_valid,
  input  logic              req_fifo_ovf,
  input  logic              mask_fifo_ovf,
  input  logic              cache_block_miss,
  input  logic              wdog_irq,
  output logic              core_halt,
  output logic              core_step,
  output logic              core_rst,
  output logic              wdog_en,
  output logic              dcache_en,
  output logic              wpost_en
);
  localparam logic [ADDR_W-1:0] MODE_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STATE_OFS = ADDR_W'(4);
  localparam logic [AW-1:0]     TRAP_LIM  = AW'(TRAP_BYTES);

  logic [7:2] mode_q;
  logic       st_miss, st_req, st_mask, st_itrap, st_dtrap;
  logic       step_q, rst_q;

  wire wr_mode  = reg_we && (reg_addr == MODE_OFS);
  wire wr_state = reg_we && (reg_addr == STATE_OFS);
  wire [31:0] clr = wr_state ? reg_wdata : 32'd0;

  wire itrap_hit = mode_q[3] && ifetch_valid && (ifetch_addr < TRAP_LIM);
  wire dtrap_hit = mode_q[2] && daccess_valid && (daccess_addr < TRAP_LIM);

  wire cause = st_req | st_mask | (st_itrap & mode_q[3]) | (st_dtrap & mode_q[2]);

  assign core_halt = cause & ~step_q;
  assign core_step = step_q;
  assign core_rst  = rst_q;
  assign wdog_en   = mode_q[7];
  assign dcache_en = mode_q[5];
  assign wpost_en  = mode_q[4];

  wire [31:0] mode_rd  = {24'd0, mode_q, 2'b00};
  wire [31:0] state_rd = {st_miss, st_req, st_mask, 24'd0, st_itrap, st_dtrap, 3'b000};

  assign reg_rdata = !reg_re                ? 32'd0 :
                     (reg_addr == MODE_OFS)  ? mode_rd :
                     (reg_addr == STATE_OFS) ? state_rd : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 6'b010000;
      st_miss  <= 1'b0;
      st_req   <= 1'b0;
      st_mask  <= 1'b0;
      st_itrap <= 1'b0;
      st_dtrap <= 1'b0;
      step_q   <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[7:2];
      if (wdog_irq) begin
        mode_q[7] <= 1'b0;
        mode_q[3] <= 1'b0;
        mode_q[2] <= 1'b0;
      end
      st_miss  <= cache_block_miss | (st_miss  & ~clr[31]);
      st_req   <= req_fifo_ovf     | (st_req   & ~clr[30]);
      st_mask  <= mask_fifo_ovf    | (st_mask  & ~clr[29]);
      st_itrap <= itrap_hit        | (st_itrap & ~clr[4]);
      st_dtrap <= dtrap_hit        | (st_dtrap & ~clr[3]);
      rst_q    <= wr_mode & reg_wdata[0];
      step_q   <= wr_mode & reg_wdata[1] & core_halt;
    end
  end
endmodule

module core_dbg_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic core_halt,
  input logic core_step,
  input logic core_rst,
  input logic wdog_en,
  input logic wdog_irq,
  input logic req_fifo_ovf,
  input logic mask_fifo_ovf,
  input logic cache_block_miss,
  input logic st_req,
  input logic st_mask,
  input logic st_miss
);
  assert_rst_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);
  assert_step_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |=> !core_step);
  assert_step_needs_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |-> $past(core_halt));
  assert_step_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |-> !core_halt);
  assert_ovf_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fifo_ovf || mask_fifo_ovf) |=> (core_halt || core_step));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_fifo_ovf |=> st_req);
  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fifo_ovf |=> st_mask);
  assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cache_block_miss |=> st_miss);
  assert_wdog_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |=> !wdog_en);
endmodule

bind core_dbg_ctl core_dbg_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .core_step(core_step),
  .core_rst(core_rst), .wdog_en(wdog_en), .wdog_irq(wdog_irq),
  .req_fifo_ovf(req_fifo_ovf), .mask_fifo_ovf(mask_fifo_ovf),
  .cache_block_miss(cache_block_miss), .st_req(st_req), .st_mask(st_mask),
  .st_miss(st_miss)
);

// File: tb/core_dbg_ctl_test.sv
module core_dbg_ctl_test;
  localparam int ADDR_W = 8;
  localparam int AW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_we = 0, reg_re = 0;
  logic [31:0] reg_rdata;
  logic [AW-1:0] ifetch_addr = '0, daccess_addr = '0;
  logic ifetch_valid = 0, daccess_valid = 0;
  logic req_fifo_ovf = 0, mask_fifo_ovf = 0, cache_block_miss = 0, wdog_irq = 0;
  logic core_halt, core_step, core_rst, wdog_en, dcache_en, wpost_en;

  int tests = 0, fails = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  core_dbg_ctl #(.ADDR_W(ADDR_W), .AW(AW), .TRAP_BYTES(256)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .ifetch_addr(ifetch_addr), .ifetch_valid(ifetch_valid),
    .daccess_addr(daccess_addr), .daccess_valid(daccess_valid),
    .req_fifo_ovf(req_fifo_ovf), .mask_fifo_ovf(mask_fifo_ovf),
    .cache_block_miss(cache_block_miss), .wdog_irq(wdog_irq),
    .core_halt(core_halt), .core_step(core_step), .core_rst(core_rst),
    .wdog_en(wdog_en), .dcache_en(dcache_en), .wpost_en(wpost_en));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1;
    #1 d = reg_rdata;
    reg_re = 0;
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    @(negedge clk);
    ifetch_addr = a; ifetch_valid = 1;
    @(negedge clk);
    ifetch_valid = 0;
  endtask

  task automatic daccess(input logic [AW-1:0] a);
    @(negedge clk);
    daccess_addr = a; daccess_valid = 1;
    @(negedge clk);
    daccess_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h0, rv); check("R1 mode", rv, 32'h40);
    rd(8'h4, rv); check("R1 state", rv, 32'h0);
    check("R1 outputs", {26'd0, core_halt, core_step, core_rst, wdog_en, dcache_en, wpost_en}, 32'h0);

    // R3 sweep of ordinary bits
    for (int v = 0; v < 16; v++) begin
      wr(8'h0, 32'(v << 4));
      rd(8'h0, rv); check("R3 readback", rv, 32'(v << 4));
      check("R3 enables", {29'd0, wdog_en, dcache_en, wpost_en},
            {29'd0, 1'(v >> 3), 1'(v >> 1), 1'(v)});
    end
    wr(8'h0, 32'h40);

    // R2 core reset pulse
    wr(8'h0, 32'h41);
    check("R2 pulse high", {31'd0, core_rst}, 32'd1);
    rd(8'h0, rv); check("R2 reads zero", rv, 32'h40);
    @(negedge clk);
    check("R2 pulse one cycle", {31'd0, core_rst}, 32'd0);

    // R11 decode
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4) begin
        rd(8'(a), rv); check("R11 unmapped", rv, 32'h0);
      end
    end
    wr(8'h8, 32'hFFFF_FFFF);
    rd(8'h0, rv); check("R11 stray write mode", rv, 32'h40);
    rd(8'h4, rv); check("R11 stray write state", rv, 32'h0);
    reg_addr = 8'h0; #1 check("R11 no read strobe", reg_rdata, 32'h0);
    wr(8'h4, 32'h1FFF_FFE7);
    rd(8'h4, rv); check("R11 read-only state", rv, 32'h0);

    // R4 instruction trap sweep
    wr(8'h0, 32'h48);
    for (int a = 0; a < 1024; a++) begin
      fetch(AW'(a));
      rd(8'h4, rv); check("R4 trap bit", rv, (a < 256) ? 32'h10 : 32'h0);
      check("R4 halt", {31'd0, core_halt}, (a < 256) ? 32'd1 : 32'd0);
      wr(8'h4, 32'h10);
      rd(8'h4, rv); check("R8 clear", rv, 32'h0);
    end
    daccess(AW'(0));
    rd(8'h4, rv); check("R5 data trap disabled", rv, 32'h0);

    // R5 data trap sweep
    wr(8'h0, 32'h44);
    for (int a = 0; a < 1024; a++) begin
      daccess(AW'(a));
      rd(8'h4, rv); check("R5 trap bit", rv, (a < 256) ? 32'h08 : 32'h0);
      check("R5 halt", {31'd0, core_halt}, (a < 256) ? 32'd1 : 32'd0);
      wr(8'h4, 32'h08);
    end
    fetch(AW'(0));
    rd(8'h4, rv); check("R4 fetch trap disabled", rv, 32'h0);
    wr(8'h0, 32'h40);
    daccess(AW'(5));
    rd(8'h4, rv); check("R5 all traps off", rv, 32'h0);

    // R6 overflow causes
    @(negedge clk); req_fifo_ovf = 1; @(negedge clk); req_fifo_ovf = 0;
    rd(8'h4, rv); check("R6 request ovf", rv, 32'h4000_0000);
    check("R6 halt req", {31'd0, core_halt}, 32'd1);
    wr(8'h4, 32'h0);
    rd(8'h4, rv); check("R8 write zero keeps", rv, 32'h4000_0000);
    wr(8'h4, 32'h4000_0000);
    check("R6 halt released", {31'd0, core_halt}, 32'd0);
    @(negedge clk); mask_fifo_ovf = 1; @(negedge clk); mask_fifo_ovf = 0;
    rd(8'h4, rv); check("R6 mask ovf", rv, 32'h2000_0000);
    check("R6 halt mask", {31'd0, core_halt}, 32'd1);
    wr(8'h4, 32'h2000_0000);

    // R7 blocking miss
    @(negedge clk); cache_block_miss = 1; @(negedge clk); cache_block_miss = 0;
    rd(8'h4, rv); check("R7 miss bit", rv, 32'h8000_0000);
    check("R7 no halt", {31'd0, core_halt}, 32'd0);
    wr(8'h4, 32'h8000_0000);
    rd(8'h4, rv); check("R7 cleared", rv, 32'h0);

    // R8 set wins over clear
    @(negedge clk);
    reg_addr = 8'h4; reg_wdata = 32'h4000_0000; reg_we = 1; req_fifo_ovf = 1;
    @(negedge clk);
    reg_we = 0; req_fifo_ovf = 0;
    rd(8'h4, rv); check("R8 set wins", rv, 32'h4000_0000);

    // R10 single step while halted
    wr(8'h0, 32'h42);
    check("R10 step high", {30'd0, core_step, core_halt}, 32'b10);
    rd(8'h0, rv); check("R10 reads zero", rv, 32'h40);
    @(negedge clk);
    check("R10 halts again", {30'd0, core_step, core_halt}, 32'b01);
    wr(8'h4, 32'h4000_0000);
    wr(8'h0, 32'h42);
    check("R10 ignored running", {30'd0, core_step, core_halt}, 32'b00);
    @(negedge clk);
    check("R10 still running", {30'd0, core_step, core_halt}, 32'b00);
    // step with cause gone afterwards
    wr(8'h0, 32'h48);
    fetch(AW'(3));
    wr(8'h0, 32'h4A);
    check("R10 step trap", {30'd0, core_step, core_halt}, 32'b10);
    wr(8'h4, 32'h10);
    check("R10 resumes", {30'd0, core_step, core_halt}, 32'b00);

    // R9 watchdog
    wr(8'h0, 32'hFC);
    @(negedge clk); wdog_irq = 1; @(negedge clk); wdog_irq = 0;
    rd(8'h0, rv); check("R9 mode after irq", rv, 32'h70);
    check("R9 wdog_en", {31'd0, wdog_en}, 32'd0);
    wr(8'h0, 32'h48);
    fetch(AW'(0));
    check("R9 trap halt", {31'd0, core_halt}, 32'd1);
    @(negedge clk); wdog_irq = 1; @(negedge clk); wdog_irq = 0;
    check("R9 halt released", {31'd0, core_halt}, 32'd0);
    rd(8'h4, rv); check("R9 cause kept", rv, 32'h10);
    wr(8'h4, 32'h10);
    @(negedge clk);
    reg_addr = 8'h0; reg_wdata = 32'hCC; reg_we = 1; wdog_irq = 1;
    @(negedge clk);
    reg_we = 0; wdog_irq = 0;
    rd(8'h0, rv); check("R9 irq beats write", rv, 32'h40);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule